// File: doc/BRIEF.md
# Low-Power Escape Sequence Transmitter

This block drives the two single-ended low-power lines of a serial data lane through an escape excursion. When a command is accepted while the lane rests in the stop state, it plays out a fixed four-step entry pattern. It then sends an eight-bit command byte, least-significant bit first, with spaced-one-hot coding: each bit is a mark state that carries its value, followed by a space state with both lines low. The excursion closes with an exit pattern back to stop.

The command byte selects what happens after it. The data-transfer code pulls further bytes from a valid/ready stream and sends each one the same way until the stream runs dry. The ultra-low-power code leaves the lines parked low until a wake request arrives. The wake-up then holds a mark-one state for a fixed number of clock cycles, set to cover the minimum 1 ms wake time, before returning to stop. Any other code is a trigger: the command alone is sent, then the exit pattern. Every mark and space lasts a programmable number of clock ticks.

Top module: `esc_lane_tx`

## Requirements
- R1: After reset, `lp_line` is 2'b11 (stop), `busy` is 0 and `data_ready` is 0. Whenever `busy` is 0, `lp_line` is 2'b11.
- R2: A command accepted in the cycle after its strobe drives `lp_line` through 2'b10, 2'b00, 2'b01, 2'b00, each for one symbol time.
- R3: Each byte is sent least-significant bit first. A 1 bit is the mark state 2'b10 and a 0 bit is the mark state 2'b01. Each mark is followed by the space state 2'b00. Mark and space each last one symbol time, and the command byte comes first.
- R4: For a trigger command, or a data-transfer command whose stream is empty, the final space is followed by 2'b10 for one symbol time and then 2'b11. `busy` stays 1 up to the last 2'b10 cycle and is never 1 while the lines show stop.
- R5: In a data-transfer excursion, `data_ready` is high for exactly the last cycle of the final space of each byte. A byte offered with `data_valid` in that cycle is sent next. If none is offered, the exit follows. `data_ready` is never raised for other commands.
- R6: After the ultra-low-power command (code `ULPS_CODE`), the lines stay at 2'b00 with `busy` high until `wake_req`. They then show 2'b10 for `WAKE_TICKS` cycles, then 2'b11 with `busy` low.
- R7: One symbol time is `sym_ticks` clock cycles. A value of 0 is treated as 1.
- R8: `cmd_start` and `ulps_req` are ignored while `busy` is high. `wake_req` is ignored unless the lane is parked in ultra-low-power.
- R9: `ulps_req` in idle starts an excursion that sends `ULPS_CODE`, whatever `cmd_byte` holds. It has priority over `cmd_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Strobe: begin an excursion with `cmd_byte` |
| cmd_byte | input | 8 | Command code sent after the entry pattern |
| ulps_req | input | 1 | Strobe: begin an ultra-low-power excursion |
| wake_req | input | 1 | Strobe: leave ultra-low-power |
| sym_ticks | input | TICK_W | Clock cycles per mark or space |
| data_valid | input | 1 | Stream byte available |
| data_byte | input | 8 | Stream byte |
| data_ready | output | 1 | Stream byte taken this cycle if valid |
| lp_line | output | 2 | Line levels {positive, negative} |
| busy | output | 1 | Excursion in progress |

## Verification
On every cycle, the embedded assertions check these rules: stop levels whenever the lane is idle, no stop level while busy, lines frozen within a symbol, space held while parked, mark-one during wake-up, and ready only on a space in data-transfer mode. The exact order of entry steps, the bit order and coding of each byte, the handling of the byte stream, symbol-length scaling, the wake duration and the ignoring of stray strobes can only be shown by the bench's scenarios. There, a per-cycle expected waveform is queued and compared against the lines.

// File: rtl/esc_tx_pkg.sv
// Package: shared state type and line-level codes for the escape transmitter.
// Assumes lines are packed as {positive, negative}.
package esc_tx_pkg;
    typedef logic [1:0] lane_t;

    localparam lane_t LN_STOP  = 2'b11;
    localparam lane_t LN_SPACE = 2'b00;
    localparam lane_t LN_MARK0 = 2'b01;
    localparam lane_t LN_MARK1 = 2'b10;

    localparam int ENTRY_LEN = 4;
    localparam int ENTRY_W   = $clog2(ENTRY_LEN);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTRY,
        ST_MARK,
        ST_SPACE,
        ST_EXIT,
        ST_HOLD,
        ST_WAKE
    } esc_state_t;

    // Line level for a given step of the entry pattern.
    function automatic lane_t entry_level(input logic [ENTRY_W-1:0] idx);
        case (idx)
            2'd0:    return LN_MARK1;
            2'd2:    return LN_MARK0;
            default: return LN_SPACE;
        endcase
    endfunction
endpackage

// File: rtl/esc_tick_timer.sv
// Symbol timer: counts cycles since the last restart and flags the final
// cycle of a phase of `limit` cycles. Assumes limit is stable within a phase;
// a limit of 0 behaves as 1.
module esc_tick_timer #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim_eff;

    // Effective phase length, never below one cycle.
    always_comb lim_eff = (limit == '0) ? CNT_W'(1) : limit;

    // Final cycle of the phase.
    always_comb done = (cnt == lim_eff - CNT_W'(1));

    // Cycle counter, cleared at each phase start.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else                   cnt <= cnt + CNT_W'(1);
    end

    assert_cnt_in_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(restart) && $stable(limit)) |-> (cnt < lim_eff));
endmodule

// File: rtl/esc_byte_shifter.sv
// Byte shifter: holds the byte in flight and presents its bits LSB first.
// Assumes load and shift are never asserted together.
module esc_byte_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              shift,
    output logic              bit_out,
    output logic              last_bit
);
    localparam int IDX_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sh;
    logic [IDX_W-1:0]  idx;

    // Current bit and end-of-byte flag.
    always_comb begin
        bit_out  = sh[0];
        last_bit = (idx == IDX_W'(BYTE_W - 1));
    end

    // Load a new byte or advance to the next bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            idx <= '0;
        end else if (load) begin
            sh  <= load_byte;
            idx <= '0;
        end else if (shift) begin
            sh  <= {1'b0, sh[BYTE_W-1:1]};
            idx <= idx + IDX_W'(1);
        end
    end

    assert_no_shift_past_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> !last_bit);
    assert_exclusive_ops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));
endmodule

// File: rtl/esc_line_encoder.sv
// Line encoder: maps sequencer state and current bit to the two line levels.
// Purely combinational; assumes the state machine in the top module.
module esc_line_encoder
    import esc_tx_pkg::*;
(
    input  esc_state_t          state,
    input  logic [ENTRY_W-1:0]  entry_idx,
    input  logic                bit_val,
    output lane_t               line
);
    // Level per state; marks carry the bit value.
    always_comb begin
        case (state)
            ST_ENTRY: line = entry_level(entry_idx);
            ST_MARK:  line = bit_val ? LN_MARK1 : LN_MARK0;
            ST_SPACE: line = LN_SPACE;
            ST_EXIT:  line = LN_MARK1;
            ST_HOLD:  line = LN_SPACE;
            ST_WAKE:  line = LN_MARK1;
            default:  line = LN_STOP;
        endcase
    end
endmodule

// File: rtl/esc_lane_tx.sv
// Escape transmitter top: sequences entry, spaced-one-hot bytes, exit,
// ultra-low-power parking and wake-up. Assumes sym_ticks is held steady
// while busy and that the stream holds data_byte steady while data_valid.
module esc_lane_tx
    import esc_tx_pkg::*;
#(
    parameter int          TICK_W     = 8,
    parameter int          WAKE_TICKS = 250000,
    parameter int          BYTE_W     = 8,
    parameter logic [7:0]  LPDT_CODE  = 8'hE1,
    parameter logic [7:0]  ULPS_CODE  = 8'h1E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [BYTE_W-1:0] cmd_byte,
    input  logic              ulps_req,
    input  logic              wake_req,
    input  logic [TICK_W-1:0] sym_ticks,
    input  logic              data_valid,
    input  logic [BYTE_W-1:0] data_byte,
    output logic              data_ready,
    output logic [1:0]        lp_line,
    output logic              busy
);
    localparam int WAKE_W = $clog2(WAKE_TICKS + 1);
    localparam int CNT_W  = (WAKE_W > TICK_W) ? WAKE_W : TICK_W;

    esc_state_t          state, state_nx;
    logic [ENTRY_W-1:0]  entry_idx, idx_nx;
    logic                lpdt_mode, lpdt_nx;
    logic                ulps_mode, ulps_nx;
    logic                sh_load, sh_shift, bit_val, bit_last;
    logic [BYTE_W-1:0]   sh_byte;
    logic                adv, t_restart, t_done;
    logic [CNT_W-1:0]    t_limit;

    // Phase length: wake-up uses the fixed hold, all else one symbol.
    always_comb t_limit = (state == ST_WAKE) ? CNT_W'(WAKE_TICKS) : CNT_W'(sym_ticks);

    // Timer restarts at each transition and while waiting on an event.
    always_comb t_restart = adv || (state == ST_IDLE) || (state == ST_HOLD);

    esc_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (t_restart),
        .limit   (t_limit),
        .done    (t_done)
    );

    esc_byte_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_byte (sh_byte),
        .shift     (sh_shift),
        .bit_out   (bit_val),
        .last_bit  (bit_last)
    );

    esc_line_encoder u_enc (
        .state     (state),
        .entry_idx (entry_idx),
        .bit_val   (bit_val),
        .line      (lp_line)
    );

    // Stream byte is taken on the last cycle of a byte's final space.
    always_comb data_ready = (state == ST_SPACE) && t_done && bit_last && lpdt_mode;

    // Busy whenever the lane has left the stop state.
    always_comb busy = (state != ST_IDLE);

    // Next-state logic for the excursion sequencer.
    always_comb begin
        state_nx = state;
        idx_nx   = entry_idx;
        lpdt_nx  = lpdt_mode;
        ulps_nx  = ulps_mode;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        sh_byte  = cmd_byte;
        adv      = 1'b0;
        case (state)
            ST_IDLE: begin
                if (ulps_req) begin
                    state_nx = ST_ENTRY;
                    idx_nx   = '0;
                    sh_load  = 1'b1;
                    sh_byte  = ULPS_CODE;
                    ulps_nx  = 1'b1;
                    lpdt_nx  = 1'b0;
                    adv      = 1'b1;
                end else if (cmd_start) begin
                    state_nx = ST_ENTRY;
                    idx_nx   = '0;
                    sh_load  = 1'b1;
                    sh_byte  = cmd_byte;
                    ulps_nx  = (cmd_byte == ULPS_CODE);
                    lpdt_nx  = (cmd_byte == LPDT_CODE);
                    adv      = 1'b1;
                end
            end
            ST_ENTRY: begin
                if (t_done) begin
                    adv = 1'b1;
                    if (entry_idx == ENTRY_W'(ENTRY_LEN - 1)) state_nx = ST_MARK;
                    else idx_nx = entry_idx + ENTRY_W'(1);
                end
            end
            ST_MARK: begin
                if (t_done) begin
                    adv      = 1'b1;
                    state_nx = ST_SPACE;
                end
            end
            ST_SPACE: begin
                if (t_done) begin
                    adv = 1'b1;
                    if (!bit_last) begin
                        sh_shift = 1'b1;
                        state_nx = ST_MARK;
                    end else if (lpdt_mode && data_valid) begin
                        sh_load  = 1'b1;
                        sh_byte  = data_byte;
                        state_nx = ST_MARK;
                    end else if (ulps_mode) begin
                        state_nx = ST_HOLD;
                    end else begin
                        state_nx = ST_EXIT;
                    end
                end
            end
            ST_EXIT: begin
                if (t_done) begin
                    adv      = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (wake_req) begin
                    adv      = 1'b1;
                    state_nx = ST_WAKE;
                end
            end
            ST_WAKE: begin
                if (t_done) begin
                    adv      = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Sequencer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            entry_idx <= '0;
            lpdt_mode <= 1'b0;
            ulps_mode <= 1'b0;
        end else begin
            state     <= state_nx;
            entry_idx <= idx_nx;
            lpdt_mode <= lpdt_nx;
            ulps_mode <= ulps_nx;
        end
    end

    assert_stop_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (lp_line == LN_STOP));
    assert_no_stop_when_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lp_line != LN_STOP));
    assert_ready_only_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |-> (lpdt_mode && lp_line == LN_SPACE));
    assert_park_space_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> (lp_line == LN_SPACE));
    assert_wake_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE) |-> (lp_line == LN_MARK1));
    assert_symbol_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != ST_IDLE && $past(state) != ST_HOLD && !$past(t_done))
        |-> $stable(lp_line));
    assert_busy_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_start || ulps_req));
endmodule

// File: tb/tb_esc_lane_tx.sv
module tb_esc_lane_tx;
    localparam int TICK_W = 8;
    localparam int WAKE_T = 20;
    localparam logic [7:0] LPDT = 8'hE1;
    localparam logic [7:0] ULPS = 8'h1E;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic ulps_req = 1'b0;
    logic wake_req = 1'b0;
    logic [TICK_W-1:0] sym_ticks = 8'd1;
    logic data_valid = 1'b0;
    logic [7:0] data_byte = 8'h00;
    logic data_ready;
    logic [1:0] lp_line;
    logic busy;

    always #2 clk = ~clk;  // 250 MHz

    esc_lane_tx #(.TICK_W(TICK_W), .WAKE_TICKS(WAKE_T), .BYTE_W(8),
                  .LPDT_CODE(LPDT), .ULPS_CODE(ULPS)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_byte(cmd_byte),
        .ulps_req(ulps_req), .wake_req(wake_req), .sym_ticks(sym_ticks),
        .data_valid(data_valid), .data_byte(data_byte), .data_ready(data_ready),
        .lp_line(lp_line), .busy(busy));

    typedef struct packed { logic [1:0] line; logic busy; logic [7:0] req; } exp_t;
    exp_t exp_q[$];
    logic [7:0] src_q[$];
    int n_cmp = 0, n_bad = 0, rdy_cnt = 0, hs_cnt = 0, cyc = 0;
    bit take_pend = 0;

    task automatic check(int req, logic [31:0] act, logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL R%0d: actual %0h expected %0h at cycle %0d", req, act, expv, cyc);
        end
    endtask

    // Monitor: pops one expected cycle per falling edge and compares.
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.req, {29'd0, lp_line, busy}, {29'd0, e.line, e.busy});
        end
    end

    // Stream source: presents queued bytes, counts ready pulses and handshakes.
    always @(negedge clk) begin
        if (take_pend) begin
            void'(src_q.pop_front());
            take_pend = 0;
        end
        data_valid = (src_q.size() > 0);
        data_byte  = (src_q.size() > 0) ? src_q[0] : 8'h00;
        if (rst_n && data_ready) begin
            rdy_cnt++;
            if (data_valid) begin
                take_pend = 1;
                hs_cnt++;
            end
        end
    end

    task automatic push_seg(logic [1:0] l, logic b, int n, int req);
        for (int i = 0; i < n; i++) exp_q.push_back('{line: l, busy: b, req: 8'(req)});
    endtask

    // R2 entry pattern
    task automatic push_entry(int s);
        push_seg(2'b10, 1, s, 2); push_seg(2'b00, 1, s, 2);
        push_seg(2'b01, 1, s, 2); push_seg(2'b00, 1, s, 2);
    endtask

    // R3 spaced-one-hot byte, LSB first
    task automatic push_byte(logic [7:0] v, int s);
        for (int i = 0; i < 8; i++) begin
            push_seg(v[i] ? 2'b10 : 2'b01, 1, s, 3);
            push_seg(2'b00, 1, s, 3);
        end
    endtask

    // R4 exit pattern then stop
    task automatic push_exit(int s);
        push_seg(2'b10, 1, s, 4);
        push_seg(2'b11, 0, 3, 4);
    endtask

    task automatic strobe_cmd(logic [7:0] c);
        @(negedge clk); cmd_byte = c; cmd_start = 1;
        @(posedge clk); #1 cmd_start = 0;
    endtask

    task automatic strobe_wake();
        @(negedge clk); wake_req = 1;
        @(posedge clk); #1 wake_req = 0;
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(1, {29'd0, lp_line, busy}, {29'd0, 2'b11, 1'b0});
        check(1, {31'd0, data_ready}, 32'd0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // Trigger, 2 ticks/symbol, with stray strobes mid-excursion (R8)
        sym_ticks = 8'd2; rdy_cnt = 0;
        strobe_cmd(8'h62);
        push_entry(2); push_byte(8'h62, 2); push_exit(2);
        repeat (7) @(negedge clk);
        cmd_byte = LPDT; cmd_start = 1; ulps_req = 1;
        @(posedge clk); #1 cmd_start = 0; ulps_req = 0;
        drain();
        check(5, rdy_cnt, 0);  // R5: no ready for trigger

        // R8: wake in idle has no effect
        strobe_wake();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(8, {29'd0, lp_line, busy}, {29'd0, 2'b11, 1'b0});
        end

        // R5: data transfer with two bytes at 1 tick/symbol
        sym_ticks = 8'd1; rdy_cnt = 0; hs_cnt = 0;
        src_q.push_back(8'hA5); src_q.push_back(8'h3C);
        repeat (2) @(negedge clk);
        strobe_cmd(LPDT);
        push_entry(1); push_byte(LPDT, 1); push_byte(8'hA5, 1); push_byte(8'h3C, 1);
        push_exit(1);
        drain();
        check(5, hs_cnt, 2);
        check(5, rdy_cnt, 3);

        // R5: data transfer with empty stream at 3 ticks/symbol
        sym_ticks = 8'd3; rdy_cnt = 0; hs_cnt = 0;
        strobe_cmd(LPDT);
        push_entry(3); push_byte(LPDT, 3); push_exit(3);
        drain();
        check(5, hs_cnt, 0);
        check(5, rdy_cnt, 1);

        // R7: zero tick count behaves as one
        sym_ticks = 8'd0;
        strobe_cmd(8'h00);
        push_entry(1); push_byte(8'h00, 1); push_exit(1);
        drain();

        // R6: ultra-low-power via command, park then wake
        sym_ticks = 8'd2; rdy_cnt = 0;
        strobe_cmd(ULPS);
        push_entry(2); push_byte(ULPS, 2); push_seg(2'b00, 1, 6, 6);
        drain();
        check(6, {29'd0, lp_line, busy}, {29'd0, 2'b00, 1'b1});
        strobe_wake();
        push_seg(2'b10, 1, WAKE_T, 6); push_seg(2'b11, 0, 3, 6);
        drain();
        check(5, rdy_cnt, 0);

        // R9: request strobe overrides cmd_byte; R8: start ignored while parked
        sym_ticks = 8'd1;
        @(negedge clk); cmd_byte = LPDT; ulps_req = 1;
        @(posedge clk); #1 ulps_req = 0;
        push_entry(1); push_byte(ULPS, 1); push_seg(2'b00, 1, 4, 9);
        drain();
        strobe_cmd(8'h62);
        repeat (3) begin
            @(negedge clk);
            check(8, {29'd0, lp_line, busy}, {29'd0, 2'b00, 1'b1});
        end
        strobe_wake();
        push_seg(2'b10, 1, WAKE_T, 6); push_seg(2'b11, 0, 3, 6);
        drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule